// File: doc/BRIEF.md
# Image Sensor Clock Generator

This block drives a linear CCD or contact image sensor from a free-running master clock. A phase counter divides the master clock into pixel periods. A pixel counter divides pixel periods into lines. A line-time counter measures master clocks since the start of the current line. Every programmable edge is a position on one of these counters.

The pixel-rate outputs are:
- a reset pulse;
- two auxiliary clamp pulses, the second of which can be disabled;
- the phase clock;
- a pair of sample strobes for correlated double sampling.

The line-rate outputs are:
- two transfer pulses;
- a clamp window that covers the optical black pixels.

The transfer pulses run in one of three modes. Normal mode uses a programmable width and guardband. The other two modes are fixed one-period contact-sensor timings that ignore the width and guardband settings.

Configuration inputs are static levels. They are changed only while reset is held. The block has no data stream, so it has no valid/ready handshake and applies no back-pressure. All pins are plain control levels.

Top module: `sensor_clk_gen`

## Requirements
- R1: The phase counter runs 0..`cfg_pix_last` and restarts at every pixel boundary. The pixel counter runs 0..`cfg_line_last`. The reset pulse is active while `cfg_rs_rise` <= phase < `cfg_rs_fall`, and the first clamp pulse likewise with its own pair. The phase clock is active while `cfg_phi_rise` <= phase < `cfg_phi_fall`. Every output shows the counter state of the previous master clock.
- R2: The second clamp pulse follows its own rise/fall pair only while `cp2_en` is 1. Otherwise it stays inactive.
- R3: The reset pulse and both clamp pulses are inactive for every pixel whose index is at least `cfg_lend_pix` (the line-end period).
- R4: The clamp window is active exactly for pixel indices p with `cfg_ob_first` <= p < `cfg_ob_end`.
- R5: Each sample strobe is one master clock wide, at phase `cfg_ref_pos` and at the effective signal phase. If `cfg_sig_pos` < `cfg_ref_pos`+2, the effective signal phase becomes `cfg_ref_pos`+2 and `sep_err_o` is 1. Otherwise it is `cfg_sig_pos` and `sep_err_o` is 0.
- R6: With `cfg_cds_en` = 0, the reference strobe never fires, the signal strobe is unchanged, and `int_ref_o` is 1. With `cfg_cds_en` = 1, `int_ref_o` is 0.
- R7: Mode 0 (also code 3) is normal mode. For line time t, transfer pulse 1 is active while G <= t < G+W, where W = `cfg_tr_width` and G = `cfg_tr_guard`. The phase clock is forced active while t < W+2G. With G = 0, the transfer pulse and the phase clock rise and fall on the same clocks.
- R8: In normal mode, transfer pulse 2 has the same width W and starts `cfg_tr2_ofs` clocks after transfer pulse 1. In modes 1 and 2 it equals transfer pulse 1.
- R9: Mode 1: transfer pulse 1 is active while `cfg_phi_rise` <= t < `cfg_phi_rise`+P, where P = `cfg_pix_last`+1. Width and guardband are ignored.
- R10: Mode 2: transfer pulse 1 is active for P clocks starting at P + (`cfg_phi_rise`+`cfg_phi_fall`)/2 − P/2, with integer division. This centers it on the phase-clock pulse of pixel 1. Width and guardband are ignored.
- R11: Bit k of `cfg_pol` inverts output k. The bit order is: reset, clamp 1, clamp 2, phase clock, reference strobe, signal strobe, transfer 1, transfer 2, clamp window.
- R12: During reset and in the first cycle after reset is released, every polarity-controlled output sits at its inactive level (equal to its `cfg_pol` bit), and `int_ref_o` and `sep_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_pix_last | input | PH_W | Master clocks per pixel minus one |
| cfg_line_last | input | PIX_W | Pixels per line minus one |
| cfg_lend_pix | input | PIX_W | First pixel of the line-end period |
| cfg_rs_rise | input | PH_W | Reset pulse rise phase |
| cfg_rs_fall | input | PH_W | Reset pulse fall phase |
| cfg_cp1_rise | input | PH_W | Clamp pulse 1 rise phase |
| cfg_cp1_fall | input | PH_W | Clamp pulse 1 fall phase |
| cfg_cp2_rise | input | PH_W | Clamp pulse 2 rise phase |
| cfg_cp2_fall | input | PH_W | Clamp pulse 2 fall phase |
| cfg_cp2_en | input | 1 | Enable for clamp pulse 2 |
| cfg_phi_rise | input | PH_W | Phase clock rise phase |
| cfg_phi_fall | input | PH_W | Phase clock fall phase |
| cfg_ref_pos | input | PH_W | Reference strobe phase |
| cfg_sig_pos | input | PH_W | Requested signal strobe phase |
| cfg_cds_en | input | 1 | 1: correlated double sampling, 0: internal reference |
| cfg_tr_mode | input | 2 | Transfer mode: 0/3 normal, 1 edge-aligned, 2 centered |
| cfg_tr_width | input | TW | Transfer width in master clocks (normal mode) |
| cfg_tr_guard | input | TW | Guardband in master clocks (normal mode) |
| cfg_tr2_ofs | input | TW | Transfer pulse 2 start offset (normal mode) |
| cfg_ob_first | input | PIX_W | First optical black pixel |
| cfg_ob_end | input | PIX_W | Pixel after the last optical black pixel |
| cfg_pol | input | 9 | Per-output inversion |
| rs_o | output | 1 | Reset pulse |
| cp1_o | output | 1 | Clamp pulse 1 |
| cp2_o | output | 1 | Clamp pulse 2 |
| phi1_o | output | 1 | Phase clock |
| smp_ref_o | output | 1 | Reference sample strobe |
| smp_sig_o | output | 1 | Signal sample strobe |
| tr1_o | output | 1 | Transfer pulse 1 |
| tr2_o | output | 1 | Transfer pulse 2 |
| clamp_o | output | 1 | Optical black clamp window |
| int_ref_o | output | 1 | Internal reference selected |
| sep_err_o | output | 1 | Sample separation was clamped |

## Verification
Every output, including the two flags, is due exactly one master clock after the counter state that produces it. In the first cycle after reset is released, outputs still show the reset levels. The bench keeps its own phase, pixel and line-time integers and derives each expected level from them. It advances the model once per clock and compares all eleven outputs at the falling edge following the rising edge that registered them. Each configuration is set up under reset and then run over several full lines, so every line-end period, clamp window and transfer window is crossed more than once.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  typedef enum logic [1:0] {
    TRM_NORMAL = 2'd0,
    TRM_EDGE   = 2'd1,
    TRM_CENTER = 2'd2,
    TRM_ALT    = 2'd3
  } tr_mode_e;

  localparam int O_RS    = 0;
  localparam int O_CP1   = 1;
  localparam int O_CP2   = 2;
  localparam int O_PHI   = 3;
  localparam int O_REF   = 4;
  localparam int O_SIG   = 5;
  localparam int O_TR1   = 6;
  localparam int O_TR2   = 7;
  localparam int O_CLAMP = 8;
  localparam int N_OUT   = 9;
endpackage

// File: rtl/sclk_timebase.sv
module sclk_timebase #(
  parameter int PH_W  = 4,
  parameter int PIX_W = 8,
  parameter int XW    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  pix_last,
  input  logic [PIX_W-1:0] line_last,
  output logic [PH_W-1:0]  phase,
  output logic [PIX_W-1:0] pix,
  output logic [XW-1:0]    ltime
);
  localparam logic [XW-1:0] LT_MAX = '1;

  logic pix_wrap, line_wrap;
  assign pix_wrap  = (phase == pix_last);
  assign line_wrap = pix_wrap && (pix == line_last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      pix   <= '0;
      ltime <= '0;
    end else begin
      phase <= pix_wrap ? '0 : phase + 1'b1;
      if (line_wrap)     pix <= '0;
      else if (pix_wrap) pix <= pix + 1'b1;
      if (line_wrap)            ltime <= '0;
      else if (ltime != LT_MAX) ltime <= ltime + 1'b1;
    end
  end
endmodule

// File: rtl/sclk_pixel_gen.sv
module sclk_pixel_gen #(
  parameter int PH_W  = 4,
  parameter int PIX_W = 8
) (
  input  logic [PH_W-1:0]  phase,
  input  logic [PIX_W-1:0] pix,
  input  logic [PIX_W-1:0] lend_pix,
  input  logic [4*PH_W-1:0] rise_v,  // rs, cp1, cp2, phi
  input  logic [4*PH_W-1:0] fall_v,
  input  logic             cp2_en,
  input  logic [PH_W-1:0]  ref_pos,
  input  logic [PH_W-1:0]  sig_pos,
  input  logic             cds_en,
  output logic [3:0]       pulse,    // rs, cp1, cp2, phi
  output logic             ref_stb,
  output logic             sig_stb,
  output logic             sep_err
);
  localparam int NP = 4;

  logic [NP-1:0] win;
  logic          in_lend;
  logic [PH_W:0] ref_min, sig_eff;

  assign in_lend = (pix >= lend_pix);

  for (genvar i = 0; i < NP; i++) begin : g_win
    assign win[i] = (phase >= rise_v[i*PH_W +: PH_W]) &&
                    (phase <  fall_v[i*PH_W +: PH_W]);
  end

  assign pulse[0] = win[0] && !in_lend;
  assign pulse[1] = win[1] && !in_lend;
  assign pulse[2] = win[2] && !in_lend && cp2_en;
  assign pulse[3] = win[3];

  assign ref_min = {1'b0, ref_pos} + (PH_W+1)'(2);
  assign sep_err = ({1'b0, sig_pos} < ref_min);
  assign sig_eff = sep_err ? ref_min : {1'b0, sig_pos};
  assign ref_stb = cds_en && (phase == ref_pos);
  assign sig_stb = ({1'b0, phase} == sig_eff);
endmodule

// File: rtl/sclk_line_gen.sv
module sclk_line_gen
  import sclk_pkg::*;
#(
  parameter int PH_W  = 4,
  parameter int PIX_W = 8,
  parameter int XW    = 12,
  parameter int TW    = 6
) (
  input  logic [PIX_W-1:0] pix,
  input  logic [XW-1:0]    ltime,
  input  tr_mode_e         mode,
  input  logic [TW-1:0]    width,
  input  logic [TW-1:0]    guard,
  input  logic [TW-1:0]    tr2_ofs,
  input  logic [PH_W-1:0]  phi_rise,
  input  logic [PH_W-1:0]  phi_fall,
  input  logic [PH_W-1:0]  pix_last,
  input  logic [PIX_W-1:0] ob_first,
  input  logic [PIX_W-1:0] ob_end,
  output logic             tr1,
  output logic             tr2,
  output logic             phi_force,
  output logic             clamp
);
  localparam int LW = XW + 2;

  logic [LW-1:0] t, w, g, per, s1, e1, s2, e2, mid;
  logic          normal;

  assign t      = LW'(ltime);
  assign w      = LW'(width);
  assign g      = LW'(guard);
  assign per    = LW'(pix_last) + LW'(1);
  assign mid    = per + ((LW'(phi_rise) + LW'(phi_fall)) >> 1);
  assign normal = (mode == TRM_NORMAL) || (mode == TRM_ALT);

  always_comb begin
    s2 = g + LW'(tr2_ofs);
    e2 = s2 + w;
    unique case (mode)
      TRM_EDGE: begin
        s1 = LW'(phi_rise);
        e1 = s1 + per;
      end
      TRM_CENTER: begin
        s1 = mid - (per >> 1);
        e1 = s1 + per;
      end
      default: begin
        s1 = g;
        e1 = g + w;
      end
    endcase
  end

  assign tr1       = (t >= s1) && (t < e1);
  assign tr2       = normal ? ((t >= s2) && (t < e2)) : tr1;
  assign phi_force = normal && (t < (w + (g << 1)));
  assign clamp     = (pix >= ob_first) && (pix < ob_end);
endmodule

// File: rtl/sensor_clk_gen.sv
module sensor_clk_gen
  import sclk_pkg::*;
#(
  parameter int PH_W  = 4,
  parameter int PIX_W = 8,
  parameter int XW    = 12,
  parameter int TW    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PH_W-1:0]  cfg_pix_last,
  input  logic [PIX_W-1:0] cfg_line_last,
  input  logic [PIX_W-1:0] cfg_lend_pix,
  input  logic [PH_W-1:0]  cfg_rs_rise,
  input  logic [PH_W-1:0]  cfg_rs_fall,
  input  logic [PH_W-1:0]  cfg_cp1_rise,
  input  logic [PH_W-1:0]  cfg_cp1_fall,
  input  logic [PH_W-1:0]  cfg_cp2_rise,
  input  logic [PH_W-1:0]  cfg_cp2_fall,
  input  logic             cfg_cp2_en,
  input  logic [PH_W-1:0]  cfg_phi_rise,
  input  logic [PH_W-1:0]  cfg_phi_fall,
  input  logic [PH_W-1:0]  cfg_ref_pos,
  input  logic [PH_W-1:0]  cfg_sig_pos,
  input  logic             cfg_cds_en,
  input  logic [1:0]       cfg_tr_mode,
  input  logic [TW-1:0]    cfg_tr_width,
  input  logic [TW-1:0]    cfg_tr_guard,
  input  logic [TW-1:0]    cfg_tr2_ofs,
  input  logic [PIX_W-1:0] cfg_ob_first,
  input  logic [PIX_W-1:0] cfg_ob_end,
  input  logic [8:0]       cfg_pol,
  output logic             rs_o,
  output logic             cp1_o,
  output logic             cp2_o,
  output logic             phi1_o,
  output logic             smp_ref_o,
  output logic             smp_sig_o,
  output logic             tr1_o,
  output logic             tr2_o,
  output logic             clamp_o,
  output logic             int_ref_o,
  output logic             sep_err_o
);
  logic [PH_W-1:0]  phase;
  logic [PIX_W-1:0] pix_idx;
  logic [XW-1:0]    ltime;
  logic [3:0]       pulse;
  logic             ref_stb, sig_stb, sep_err;
  logic             tr1, tr2, phi_force, clamp;
  logic [N_OUT-1:0] raw, raw_q, outv;
  logic             int_ref_q, sep_err_q;

  sclk_timebase #(.PH_W(PH_W), .PIX_W(PIX_W), .XW(XW)) u_tb (
    .clk(clk), .rst_n(rst_n), .pix_last(cfg_pix_last),
    .line_last(cfg_line_last), .phase(phase), .pix(pix_idx), .ltime(ltime)
  );

  sclk_pixel_gen #(.PH_W(PH_W), .PIX_W(PIX_W)) u_px (
    .phase(phase), .pix(pix_idx), .lend_pix(cfg_lend_pix),
    .rise_v({cfg_phi_rise, cfg_cp2_rise, cfg_cp1_rise, cfg_rs_rise}),
    .fall_v({cfg_phi_fall, cfg_cp2_fall, cfg_cp1_fall, cfg_rs_fall}),
    .cp2_en(cfg_cp2_en), .ref_pos(cfg_ref_pos), .sig_pos(cfg_sig_pos),
    .cds_en(cfg_cds_en), .pulse(pulse), .ref_stb(ref_stb),
    .sig_stb(sig_stb), .sep_err(sep_err)
  );

  sclk_line_gen #(.PH_W(PH_W), .PIX_W(PIX_W), .XW(XW), .TW(TW)) u_ln (
    .pix(pix_idx), .ltime(ltime), .mode(tr_mode_e'(cfg_tr_mode)),
    .width(cfg_tr_width), .guard(cfg_tr_guard), .tr2_ofs(cfg_tr2_ofs),
    .phi_rise(cfg_phi_rise), .phi_fall(cfg_phi_fall),
    .pix_last(cfg_pix_last), .ob_first(cfg_ob_first), .ob_end(cfg_ob_end),
    .tr1(tr1), .tr2(tr2), .phi_force(phi_force), .clamp(clamp)
  );

  always_comb begin
    raw          = '0;
    raw[O_RS]    = pulse[0];
    raw[O_CP1]   = pulse[1];
    raw[O_CP2]   = pulse[2];
    raw[O_PHI]   = pulse[3] || phi_force;
    raw[O_REF]   = ref_stb;
    raw[O_SIG]   = sig_stb;
    raw[O_TR1]   = tr1;
    raw[O_TR2]   = tr2;
    raw[O_CLAMP] = clamp;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      raw_q     <= '0;
      int_ref_q <= 1'b0;
      sep_err_q <= 1'b0;
    end else begin
      raw_q     <= raw;
      int_ref_q <= !cfg_cds_en;
      sep_err_q <= sep_err;
    end
  end

  assign outv      = raw_q ^ cfg_pol;
  assign rs_o      = outv[O_RS];
  assign cp1_o     = outv[O_CP1];
  assign cp2_o     = outv[O_CP2];
  assign phi1_o    = outv[O_PHI];
  assign smp_ref_o = outv[O_REF];
  assign smp_sig_o = outv[O_SIG];
  assign tr1_o     = outv[O_TR1];
  assign tr2_o     = outv[O_TR2];
  assign clamp_o   = outv[O_CLAMP];
  assign int_ref_o = int_ref_q;
  assign sep_err_o = sep_err_q;
endmodule

// File: rtl/sclk_chk.sv
module sclk_chk
  import sclk_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [8:0]       cfg_pol,
  input logic             cfg_cp2_en,
  input logic [PIX_W-1:0] cfg_lend_pix,
  input logic [PIX_W-1:0] cfg_ob_first,
  input logic [PIX_W-1:0] cfg_ob_end,
  input logic [PIX_W-1:0] pix,
  input logic             rs_o,
  input logic             cp1_o,
  input logic             cp2_o,
  input logic             smp_ref_o,
  input logic             smp_sig_o,
  input logic             clamp_o,
  input logic             int_ref_o
);
  logic             seen;
  logic [PIX_W-1:0] pix_q;
  logic             ref_act, sig_act, rs_act, cp1_act, cp2_act, clamp_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen  <= 1'b0;
      pix_q <= '0;
    end else begin
      seen  <= 1'b1;
      pix_q <= pix;
    end
  end

  assign rs_act    = rs_o      ^ cfg_pol[O_RS];
  assign cp1_act   = cp1_o     ^ cfg_pol[O_CP1];
  assign cp2_act   = cp2_o     ^ cfg_pol[O_CP2];
  assign ref_act   = smp_ref_o ^ cfg_pol[O_REF];
  assign sig_act   = smp_sig_o ^ cfg_pol[O_SIG];
  assign clamp_act = clamp_o   ^ cfg_pol[O_CLAMP];

  AST_LINE_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && pix_q >= cfg_lend_pix) |-> !(rs_act || cp1_act || cp2_act)); // R3
  AST_CP2_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_cp2_en |-> !cp2_act); // R2
  AST_CLAMP_OB_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    seen |-> (clamp_act == (pix_q >= cfg_ob_first && pix_q < cfg_ob_end))); // R4
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ref_act, sig_act})); // R5
  AST_SIG_NOT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ref_act |=> !sig_act); // R5
  AST_INTREF_NO_REF: assert property (@(posedge clk) disable iff (!rst_n)
    int_ref_o |-> !ref_act); // R6
endmodule

bind sensor_clk_gen sclk_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_pol(cfg_pol), .cfg_cp2_en(cfg_cp2_en),
  .cfg_lend_pix(cfg_lend_pix), .cfg_ob_first(cfg_ob_first),
  .cfg_ob_end(cfg_ob_end), .pix(pix_idx), .rs_o(rs_o), .cp1_o(cp1_o),
  .cp2_o(cp2_o), .smp_ref_o(smp_ref_o), .smp_sig_o(smp_sig_o),
  .clamp_o(clamp_o), .int_ref_o(int_ref_o)
);

// File: tb/sensor_clk_gen_test.sv
module sensor_clk_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int PH_W = 4, PIX_W = 8, XW = 12, TW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PH_W-1:0]  cfg_pix_last, cfg_rs_rise, cfg_rs_fall, cfg_cp1_rise, cfg_cp1_fall;
  logic [PH_W-1:0]  cfg_cp2_rise, cfg_cp2_fall, cfg_phi_rise, cfg_phi_fall, cfg_ref_pos, cfg_sig_pos;
  logic [PIX_W-1:0] cfg_line_last, cfg_lend_pix, cfg_ob_first, cfg_ob_end;
  logic cfg_cp2_en, cfg_cds_en;
  logic [1:0] cfg_tr_mode;
  logic [TW-1:0] cfg_tr_width, cfg_tr_guard, cfg_tr2_ofs;
  logic [8:0] cfg_pol;
  logic rs_o, cp1_o, cp2_o, phi1_o, smp_ref_o, smp_sig_o, tr1_o, tr2_o, clamp_o, int_ref_o, sep_err_o;

  int n_tests = 0;
  int n_fail  = 0;
  int m_ph, m_px, m_t;
  logic [10:0] exp_v;

  always #(CLK_PERIOD/2) clk = ~clk;

  sensor_clk_gen #(.PH_W(PH_W), .PIX_W(PIX_W), .XW(XW), .TW(TW)) uut (.*);

  function automatic logic win(int v, int lo, int hi);
    return (v >= lo) && (v < hi);
  endfunction

  // bit order: 0..8 polarity-controlled outputs, 9 int_ref, 10 sep_err
  function automatic logic [10:0] model_out(int ph, int px, int t);
    logic [8:0] r;
    int per, s, mid, sig_eff, g, w;
    logic normal;
    per    = int'(cfg_pix_last) + 1;
    g      = int'(cfg_tr_guard);
    w      = int'(cfg_tr_width);
    normal = (cfg_tr_mode == 2'd0) || (cfg_tr_mode == 2'd3);
    sig_eff = (int'(cfg_sig_pos) < int'(cfg_ref_pos) + 2) ? int'(cfg_ref_pos) + 2 : int'(cfg_sig_pos);
    r[0] = win(ph, cfg_rs_rise, cfg_rs_fall) && px < int'(cfg_lend_pix);               // R1 R3
    r[1] = win(ph, cfg_cp1_rise, cfg_cp1_fall) && px < int'(cfg_lend_pix);
    r[2] = cfg_cp2_en && win(ph, cfg_cp2_rise, cfg_cp2_fall) && px < int'(cfg_lend_pix); // R2
    r[3] = win(ph, cfg_phi_rise, cfg_phi_fall) || (normal && t < w + 2*g);              // R7
    r[4] = cfg_cds_en && ph == int'(cfg_ref_pos);                                      // R6
    r[5] = ph == sig_eff;                                                              // R5
    if (cfg_tr_mode == 2'd1) r[6] = win(t, cfg_phi_rise, int'(cfg_phi_rise) + per);    // R9
    else if (cfg_tr_mode == 2'd2) begin                                                // R10
      mid = per + (int'(cfg_phi_rise) + int'(cfg_phi_fall)) / 2;
      s = mid - per / 2;
      r[6] = win(t, s, s + per);
    end else r[6] = win(t, g, g + w);
    r[7] = normal ? win(t, g + int'(cfg_tr2_ofs), g + int'(cfg_tr2_ofs) + w) : r[6];   // R8
    r[8] = win(px, cfg_ob_first, cfg_ob_end);                                          // R4
    return {int'(cfg_sig_pos) < int'(cfg_ref_pos) + 2, !cfg_cds_en, r ^ cfg_pol};      // R11
  endfunction

  task automatic check(string what, string req, logic act, logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
    end
  endtask

  task automatic check_all(string req);
    check("rs",      {req, " R3"}, rs_o,      exp_v[0]);
    check("cp1",     {req, " R3"}, cp1_o,     exp_v[1]);
    check("cp2",     {req, " R2"}, cp2_o,     exp_v[2]);
    check("phi1",    {req, " R7"}, phi1_o,    exp_v[3]);
    check("ref",     {req, " R6"}, smp_ref_o, exp_v[4]);
    check("sig",     {req, " R5"}, smp_sig_o, exp_v[5]);
    check("tr1",     {req, " R9 R10"}, tr1_o, exp_v[6]);
    check("tr2",     {req, " R8"}, tr2_o,     exp_v[7]);
    check("clamp",   {req, " R4"}, clamp_o,   exp_v[8]);
    check("int_ref", {req, " R6"}, int_ref_o, exp_v[9]);
    check("sep_err", {req, " R5"}, sep_err_o, exp_v[10]);
  endtask

  task automatic run_cfg(string req, int cycles);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    exp_v = {2'b00, cfg_pol};
    check_all({req, " R12 reset"});
    rst_n = 1'b1;
    m_ph = 0; m_px = 0; m_t = 0;
    check_all({req, " R12 first"});
    for (int i = 0; i < cycles; i++) begin
      exp_v = model_out(m_ph, m_px, m_t);
      if (m_ph == int'(cfg_pix_last)) begin
        m_ph = 0;
        if (m_px == int'(cfg_line_last)) begin m_px = 0; m_t = 0; end
        else begin m_px++; m_t++; end
      end else begin m_ph++; m_t++; end
      @(negedge clk);
      check_all({req, " R1"});
    end
  endtask

  task automatic base_cfg();
    cfg_pix_last = 4'd5;  cfg_line_last = 8'd9; cfg_lend_pix = 8'd7;
    cfg_rs_rise = 4'd0;   cfg_rs_fall = 4'd2;
    cfg_cp1_rise = 4'd1;  cfg_cp1_fall = 4'd3;
    cfg_cp2_rise = 4'd2;  cfg_cp2_fall = 4'd5; cfg_cp2_en = 1'b1;
    cfg_phi_rise = 4'd1;  cfg_phi_fall = 4'd4;
    cfg_ref_pos = 4'd1;   cfg_sig_pos = 4'd4;  cfg_cds_en = 1'b1;
    cfg_tr_mode = 2'd0;   cfg_tr_width = 6'd3; cfg_tr_guard = 6'd2; cfg_tr2_ofs = 6'd1;
    cfg_ob_first = 8'd1;  cfg_ob_end = 8'd3;   cfg_pol = 9'h000;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    base_cfg();
    @(negedge clk);
    run_cfg("R7 normal guard", 200);
    base_cfg(); cfg_tr_guard = 6'd0; cfg_pol = 9'h1FF; cfg_cp2_en = 1'b0;
    cfg_cds_en = 1'b0; cfg_sig_pos = 4'd2;
    run_cfg("R7 R11 R6 R5 zero guard inverted", 200);
    base_cfg(); cfg_tr_mode = 2'd1; cfg_pol = 9'h0A5; cfg_pix_last = 4'd7;
    cfg_ob_first = 8'd0; cfg_ob_end = 8'd9; cfg_lend_pix = 8'd9;
    run_cfg("R9 edge mode", 220);
    base_cfg(); cfg_tr_mode = 2'd2; cfg_line_last = 8'd6; cfg_lend_pix = 8'd5;
    run_cfg("R10 centered mode", 200);
    base_cfg(); cfg_tr_mode = 2'd3; cfg_tr2_ofs = 6'd0; cfg_ref_pos = 4'd3; cfg_sig_pos = 4'd3;
    run_cfg("R8 R5 alt normal", 200);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule